// File: doc/BRIEF.md
# Two-Way Skewed-Associative Read Cache

This block is a 256-byte read-only cache in front of a 16 KB byte-addressed memory. It holds 4-byte lines in two ways of 32 lines each. The two ways are indexed differently. Way 0 takes the five block-address bits just above the byte offset as its index. Way 1 takes those same five bits XORed with the next five block-address bits. Two blocks that compete for one line in way 0 are therefore usually spread across different lines in way 1. This reduces conflict misses when an access pattern strides through memory.

A requester presents a byte address with a valid/ready handshake. Both ways are probed in the same cycle. On a hit, the addressed byte is returned in the next cycle. On a miss, the cache stalls further requests and drives a refill request carrying the 12-bit block address. When the 32-bit line comes back with a one-cycle valid pulse, the cache writes it into one of the block's two candidate lines and answers in the following cycle.

Every line stores the complete block address as its tag, because a hashed index cannot be inverted. Each line also carries a single recency flag. Victim choice compares the flags of the two candidate lines, since the two candidates do not share a set-wide history.

Top module: `skew_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, fill_req_valid is 0, and every line is invalid, so the first lookup of any address misses.
- R2: rsp_data is byte number addr[1:0] of the line, where byte k is bits [8k+7:8k] of the 32-bit line as delivered on fill_data.
- R3: A request accepted while the block is resident gives rsp_valid=1 and rsp_hit=1 in the very next cycle, and no refill request is raised.
- R4: On a miss, from the cycle after acceptance until fill_valid is seen: fill_req_valid is 1, fill_req_addr holds addr[13:2] unchanged, and req_ready is 0. In the cycle after fill_valid, rsp_valid=1 and rsp_hit=0, with the byte taken from the refilled line.
- R5: A block with address bits b[11:0] = addr[13:2] can reside at line b[4:0] of way 0 or at line b[4:0] XOR b[9:5] of way 1. Two blocks with the same way-0 line can therefore be resident together and both hit.
- R6: On a miss, an invalid candidate line is filled before any valid line is evicted. If both candidate lines are invalid, way 0 is filled.
- R7: When both candidates are valid, the one whose recency flag is clear is replaced, and way 0 is replaced on a tie. The flag of a line is set when that line hits or is filled, and at the same moment the flag of the block's candidate line in the other way is cleared.
- R8: A fill_valid pulse while no refill is outstanding changes nothing: it produces no response and leaves the cached contents untouched.
- R9: rsp_valid is a single-cycle pulse per request, and req_ready is back at 1 in the cycle after the response.
- R10: The tag compares all 12 block-address bits, so blocks that differ only in addr[13:12] are never mistaken for each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_addr | input | 14 | Byte address of the lookup |
| rsp_valid | output | 1 | Response byte valid, one cycle |
| rsp_hit | output | 1 | Response was served without a refill |
| rsp_data | output | 8 | Addressed byte |
| fill_req_valid | output | 1 | Refill outstanding |
| fill_req_addr | output | 12 | Block address to refill |
| fill_valid | input | 1 | Refill line delivered this cycle |
| fill_data | input | 32 | Refill line, byte 0 in the low bits |

## Verification
The checker relies on the memory side being consistent. A fill_valid pulse only answers the outstanding block address and carries that block's line. No other agent changes memory, so a block is never placed twice and at most one way can ever match. It also expects fill_valid to be a one-cycle pulse. The stimulus follows this: the bench keeps a fixed data pattern per block address, returns exactly that pattern after a fixed delay, and sends a single stray pulse only while the cache is idle, to exercise R8.

// File: rtl/skc_pkg.sv
package skc_pkg;

    localparam int DEF_ADDR_W = 14;
    localparam int DEF_OFF_W  = 2;
    localparam int DEF_IDX_W  = 5;
    localparam int BYTE_W     = 8;
    localparam int NUM_WAYS   = 2;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REFILL = 1'b1
    } skc_state_e;

    // Way selected for replacement: way 1 only when it is strictly the better victim.
    function automatic logic pick_way1(input logic v0, input logic v1,
                                       input logic r0, input logic r1);
        return (v0 && !v1) || (v0 && v1 && r0 && !r1);
    endfunction

endpackage

// File: rtl/skc_index.sv
module skc_index #(
    parameter int BLK_W = 12,
    parameter int IDX_W = 5
) (
    input  logic [BLK_W-1:0] blk,
    output logic [IDX_W-1:0] idx_plain,
    output logic [IDX_W-1:0] idx_hash
);
    assign idx_plain = blk[IDX_W-1:0];

    for (genvar i = 0; i < IDX_W; i++) begin : g_fold
        if (i + IDX_W < BLK_W) begin : g_xor
            assign idx_hash[i] = blk[i] ^ blk[i+IDX_W];
        end else begin : g_pass
            assign idx_hash[i] = blk[i];
        end
    end
endmodule

// File: rtl/skc_way.sv
module skc_way #(
    parameter int IDX_W  = 5,
    parameter int TAG_W  = 12,
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              hit,
    output logic              valid,
    output logic              recent,
    output logic [LINE_W-1:0] data,
    input  logic              upd_en,
    input  logic              upd_recent,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_data
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   vld_q;
    logic [SETS-1:0]   rec_q;
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [LINE_W-1:0] dat_q [SETS];

    assign valid  = vld_q[idx];
    assign recent = rec_q[idx];
    assign data   = dat_q[idx];
    assign hit    = vld_q[idx] && (tag_q[idx] == look_tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            rec_q <= '0;
        end else if (fill_en) begin
            vld_q[idx] <= 1'b1;
            rec_q[idx] <= 1'b1;
        end else if (upd_en) begin
            rec_q[idx] <= upd_recent;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx] <= look_tag;
            dat_q[idx] <= fill_data;
        end
    end
endmodule

// File: rtl/skc_victim.sv
module skc_victim
    import skc_pkg::*;
(
    input  logic [NUM_WAYS-1:0] cand_valid,
    input  logic [NUM_WAYS-1:0] cand_recent,
    output logic                victim
);
    assign victim = pick_way1(cand_valid[0], cand_valid[1],
                              cand_recent[0], cand_recent[1]);
endmodule

// File: rtl/skew_cache.sv
module skew_cache
    import skc_pkg::*;
#(
    parameter int  ADDR_W = DEF_ADDR_W,
    parameter int  OFF_W  = DEF_OFF_W,
    parameter int  IDX_W  = DEF_IDX_W,
    localparam int BLK_W  = ADDR_W - OFF_W,
    localparam int LINE_W = BYTE_W << OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [BYTE_W-1:0] rsp_data,
    output logic              fill_req_valid,
    output logic [BLK_W-1:0]  fill_req_addr,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_data
);
    skc_state_e        state_q;
    logic [ADDR_W-1:0] miss_addr_q;
    logic              rsp_valid_q;
    logic              rsp_hit_q;
    logic [BYTE_W-1:0] rsp_data_q;

    logic [BLK_W-1:0]    look_blk;
    logic [IDX_W-1:0]    way_idx [NUM_WAYS];
    logic [NUM_WAYS-1:0] way_hit;
    logic [NUM_WAYS-1:0] cand_valid;
    logic [NUM_WAYS-1:0] cand_recent;
    logic [LINE_W-1:0]   way_data [NUM_WAYS];
    logic [NUM_WAYS-1:0] upd_en;
    logic [NUM_WAYS-1:0] upd_val;
    logic [NUM_WAYS-1:0] fill_we;
    logic                victim;
    logic                lookup_hit;
    logic                hit_way;
    logic                accept;
    logic                fill_fire;

    function automatic logic [BYTE_W-1:0] byte_of(input logic [LINE_W-1:0] line,
                                                  input logic [OFF_W-1:0]  off);
        logic [LINE_W-1:0] sh;
        sh = line >> ({off, 3'b000});
        return sh[BYTE_W-1:0];
    endfunction

    // The lookup index follows the request when idle and the pending miss during refill.
    assign look_blk = (state_q == ST_REFILL) ? miss_addr_q[ADDR_W-1:OFF_W]
                                             : req_addr[ADDR_W-1:OFF_W];

    skc_index #(.BLK_W(BLK_W), .IDX_W(IDX_W)) u_index (
        .blk       (look_blk),
        .idx_plain (way_idx[0]),
        .idx_hash  (way_idx[1])
    );

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        skc_way #(.IDX_W(IDX_W), .TAG_W(BLK_W), .LINE_W(LINE_W)) u_way (
            .clk        (clk),
            .rst        (rst),
            .idx        (way_idx[w]),
            .look_tag   (look_blk),
            .hit        (way_hit[w]),
            .valid      (cand_valid[w]),
            .recent     (cand_recent[w]),
            .data       (way_data[w]),
            .upd_en     (upd_en[w]),
            .upd_recent (upd_val[w]),
            .fill_en    (fill_we[w]),
            .fill_data  (fill_data)
        );
    end

    skc_victim u_victim (
        .cand_valid  (cand_valid),
        .cand_recent (cand_recent),
        .victim      (victim)
    );

    assign lookup_hit = |way_hit;
    assign hit_way    = way_hit[1] && !way_hit[0];
    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign fill_fire  = (state_q == ST_REFILL) && fill_valid;

    always_comb begin
        upd_en  = '0;
        upd_val = '0;
        fill_we = '0;
        if (accept && lookup_hit) begin
            upd_en           = '1;
            upd_val[hit_way] = 1'b1;
        end
        if (fill_fire) begin
            fill_we[victim]  = 1'b1;
            upd_en[!victim]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            miss_addr_q <= '0;
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (lookup_hit) begin
                            rsp_valid_q <= 1'b1;
                            rsp_hit_q   <= 1'b1;
                            rsp_data_q  <= byte_of(way_data[hit_way], req_addr[OFF_W-1:0]);
                        end else begin
                            miss_addr_q <= req_addr;
                            state_q     <= ST_REFILL;
                        end
                    end
                end
                ST_REFILL: begin
                    if (fill_valid) begin
                        rsp_valid_q <= 1'b1;
                        rsp_hit_q   <= 1'b0;
                        rsp_data_q  <= byte_of(fill_data, miss_addr_q[OFF_W-1:0]);
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready      = (state_q == ST_IDLE);
    assign rsp_valid      = rsp_valid_q;
    assign rsp_hit        = rsp_hit_q;
    assign rsp_data       = rsp_data_q;
    assign fill_req_valid = (state_q == ST_REFILL);
    assign fill_req_addr  = miss_addr_q[ADDR_W-1:OFF_W];
endmodule

// File: rtl/skew_cache_chk.sv
module skew_cache_chk #(
    parameter int BLK_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             fill_req_valid,
    input logic [BLK_W-1:0] fill_req_addr,
    input logic             fill_valid,
    input logic             lookup_hit,
    input logic [1:0]       way_hit,
    input logic [1:0]       fill_we,
    input logic [1:0]       cand_valid
);
    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && lookup_hit) |=> (rsp_valid && rsp_hit)); // R3

    AST_MISS_RAISES_REFILL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !lookup_hit) |=> (fill_req_valid && !rsp_valid)); // R4

    AST_REFILL_STALLS: assert property (@(posedge clk) disable iff (rst)
        fill_req_valid |-> !req_ready); // R4

    AST_REFILL_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (fill_req_valid && !fill_valid) |=> (fill_req_valid && $stable(fill_req_addr))); // R4

    AST_REFILL_ANSWERS: assert property (@(posedge clk) disable iff (rst)
        (fill_req_valid && fill_valid) |=> (rsp_valid && !rsp_hit)); // R4

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        !(way_hit[0] && way_hit[1])); // R5

    AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (rst)
        fill_we[1] |-> cand_valid[0]); // R6

    AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fill_we)); // R7

    AST_STRAY_FILL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !fill_req_valid && !req_valid) |=> !rsp_valid); // R8
endmodule

bind skew_cache skew_cache_chk #(.BLK_W(BLK_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .fill_req_valid (fill_req_valid),
    .fill_req_addr  (fill_req_addr),
    .fill_valid     (fill_valid),
    .lookup_hit     (lookup_hit),
    .way_hit        (way_hit),
    .fill_we        (fill_we),
    .cand_valid     (cand_valid)
);

// File: tb/skew_cache_tb.sv
`timescale 1ns/1ps
module skew_cache_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [7:0]  rsp_data;
    logic        fill_req_valid;
    logic [11:0] fill_req_addr;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    skew_cache u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    function automatic logic [31:0] pat(input logic [11:0] b);
        return {b[7:0] ^ 8'h3C, 4'h5, b[11:8], b[7:0] ^ 8'hC3, 4'hA, b[11:8]};
    endfunction

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // One lookup; services a refill if one is raised and checks the outcome.
    task automatic do_read(input logic [13:0] a, input bit exp_hit, input string rq);
        logic [11:0] b;
        logic [31:0] ln;
        logic [7:0]  eb;
        b  = a[13:2];
        ln = pat(b);
        eb = 8'(ln >> (8 * a[1:0]));
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (rsp_valid) begin
            check(exp_hit, rq, 32'(rsp_hit), 32'(exp_hit));
            check(rsp_hit == 1'b1 && !fill_req_valid, "R3", {30'd0, rsp_hit, fill_req_valid}, 32'h2);
            check(rsp_data == eb, "R2", 32'(rsp_data), 32'(eb));
        end else begin
            check(!exp_hit, rq, 32'(0), 32'(exp_hit));
            check(fill_req_valid && fill_req_addr == b && !req_ready, "R4",
                  {fill_req_valid, req_ready, 18'd0, fill_req_addr}, {2'b10, 18'd0, b});
            repeat (2) @(negedge clk);
            check(fill_req_valid && fill_req_addr == b && !rsp_valid, "R4",
                  {fill_req_valid, rsp_valid, 18'd0, fill_req_addr}, {2'b10, 18'd0, b});
            fill_valid = 1'b1;
            fill_data  = ln;
            @(negedge clk);
            fill_valid = 1'b0;
            fill_data  = 32'hDEAD_BEEF;
            check(rsp_valid && !rsp_hit, "R4", {30'd0, rsp_valid, rsp_hit}, 32'h2);
            check(rsp_data == eb, "R2", 32'(rsp_data), 32'(eb));
        end
        @(negedge clk);
        check(!rsp_valid && req_ready, "R9", {30'd0, rsp_valid, req_ready}, 32'h1);
    endtask

    task automatic t_reset_state();
        do_reset();
        check(req_ready && !rsp_valid && !fill_req_valid, "R1",
              {29'd0, req_ready, rsp_valid, fill_req_valid}, 32'h4);
    endtask

    task automatic t_first_and_bytes();
        do_read(14'h0000, 1'b0, "R1");
        do_read(14'h0001, 1'b1, "R2");
        do_read(14'h0002, 1'b1, "R2");
        do_read(14'h0003, 1'b1, "R2");
    endtask

    task automatic t_coexist();
        // block 0x020 shares way-0 line 0 with block 0x000; its way-1 line is 1
        do_read(14'h0080, 1'b0, "R6");
        do_read(14'h0000, 1'b1, "R5");
        do_read(14'h0082, 1'b1, "R5");
    endtask

    task automatic t_full_tag();
        // block 0xC00 differs from block 0x000 only in addr[13:12]
        do_read(14'h3000, 1'b0, "R10");
        do_read(14'h0001, 1'b1, "R10");
        do_read(14'h3003, 1'b1, "R10");
    endtask

    task automatic t_stray_fill();
        @(negedge clk);
        fill_valid = 1'b1;
        fill_data  = 32'h1234_5678;
        @(negedge clk);
        fill_valid = 1'b0;
        check(!rsp_valid && req_ready, "R8", {30'd0, rsp_valid, req_ready}, 32'h1);
        do_read(14'h0002, 1'b1, "R8");
    endtask

    task automatic t_victim();
        do_reset();
        do_read(14'h0000, 1'b0, "R6");  // A 0x000 -> way0[0]
        do_read(14'h0080, 1'b0, "R6");  // B 0x020 -> way1[1]
        do_read(14'h0004, 1'b0, "R6");  // X 0x001 -> way0[1]
        do_read(14'h1080, 1'b0, "R7");  // Y 0x420: both flags clear, way0 (A) replaced
        do_read(14'h2080, 1'b0, "R7");  // Z 0x820: way0 flag set, way1 (B) replaced
        do_read(14'h1081, 1'b1, "R7");  // Y kept
        do_read(14'h2082, 1'b1, "R7");  // Z kept
        do_read(14'h0083, 1'b0, "R7");  // B was evicted; replaces Y in way0
        do_read(14'h0001, 1'b0, "R7");  // A was evicted; goes to invalid way1[0]
        do_read(14'h0007, 1'b1, "R7");  // X untouched
        do_read(14'h2081, 1'b1, "R7");  // Z still resident
        do_read(14'h1080, 1'b0, "R7");  // Y was replaced by B
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_first_and_bytes();
        t_coexist();
        t_full_tag();
        t_stray_fill();
        t_victim();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule